// File: doc/BRIEF.md
# Flash Bulk Erase Sequencer

This controller sits on the host side of a byte-wide flash array and carries out a complete, verified whole-array erase. It first charges every byte to 00H using a pulsed program step: it writes a program-setup command, writes the data byte, waits a timed program pulse, and then issues a program-verify command and a read. It repeats this for each byte until the byte reads back 00H.

With the array fully charged, the controller enters an erase loop. Each round issues a double erase command, waits a timed erase pulse, and then scans the array with an erase-verify command followed by a read at each address. The scan moves upward until it finds a byte that does not read FFH. The address where the scan stopped is kept, and the scan after the next erase pulse starts there, so bytes that already verified are not read again. When the last address verifies, the controller writes a read command and raises `done`. It raises `fail` when a byte cannot be programmed within the allowed number of tries, or when another erase pulse would exceed the pulse limit.

The array side is one request channel and one read-return channel. A request is offered with `bus_valid` and accepted on a cycle where `bus_ready` is also high. Until that cycle the request's write flag, address and data stay unchanged. The device may hold `bus_ready` low for as long as it needs. A read request is answered later by a single-cycle `rd_valid` with its data. No further request is offered before that answer arrives.

Top module: `flash_bulk_eraser`

## Requirements
- R1: After reset, `busy`, `done`, `fail` and `bus_valid` are all low.
- R2: A request that is offered but not yet accepted keeps `bus_valid`, `bus_write`, `bus_addr` and `bus_wdata` unchanged until `bus_ready` accepts it. After an accepted read (`bus_write`=0), no request is offered until `rd_valid` has returned.
- R3: Pre-program runs from address 0 to the last address. For each address it repeats the following cycle until the read returns 00H: write 40H at the address, write 00H at the address, wait at least PROG_PULSE_CYC cycles, write C0H, then read the address.
- R4: If one byte still does not read 00H after PROG_TRIES program pulses, the controller raises `fail` and issues no erase command (20H).
- R5: Every erase pulse is two consecutive 20H writes. The next request comes at least ERASE_PULSE_CYC cycles after the second 20H write is accepted.
- R6: Erase-verify at an address is a write of A0H followed by a read of the same address. A read result of FFH moves the scan to the next address.
- R7: The first scan starts at address 0. A read result other than FFH ends the scan and triggers a new erase pulse. The following scan restarts at the address that failed, so with N pulses in a successful run the controller issues exactly DEPTH+N-1 A0H commands.
- R8: When the last address reads FFH, the controller writes the read command 00H, lowers `busy` and raises `done`. `done` stays high until the next `start`.
- R9: If a scan fails after ERASE_MAX pulses have already been issued, the controller raises `fail` and issues no further erase pulse.
- R10: A `start` pulse while `busy` is high has no effect on the sequence in progress.
- R11: `done` and `fail` are never high together. A `start` while idle clears both and raises `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a full erase (used only when not busy) |
| bus_valid | output | 1 | Request offered to the array |
| bus_ready | input | 1 | Array accepts the offered request |
| bus_write | output | 1 | 1 = command/data write, 0 = read |
| bus_addr | output | ADDR_W | Byte address of the request |
| bus_wdata | output | 8 | Command or data byte for writes |
| rd_valid | input | 1 | Read data returned (one cycle) |
| rd_data | input | 8 | Returned byte |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Erase completed and verified |
| fail | output | 1 | Program-try or erase-pulse limit hit |

## Verification
The array model is given a separate count of program pulses and erase pulses for each byte. One pattern has single-pulse bytes scattered among slow bytes. In that pattern the pulse count and the A0H count separate a scan that resumes from one that restarts at zero. A second pattern adds multi-try program bytes, an intermittent `bus_ready` and a stray `start` in the middle of a run, which tests request stability and whether the stray start is ignored. Two limit patterns use one byte that never programs and one byte that needs more erase pulses than allowed. These show that each fail path stops at exactly the limit and issues no later erase writes.

// File: rtl/fe_pkg.sv
package fe_pkg;
  typedef logic [7:0] byte_t;

  localparam byte_t CMD_PROG_SETUP   = 8'h40;
  localparam byte_t CMD_PROG_CHECK   = 8'hC0;
  localparam byte_t CMD_ERASE        = 8'h20;
  localparam byte_t CMD_ERASE_CHECK  = 8'hA0;
  localparam byte_t CMD_READ_ARRAY   = 8'h00;
  localparam byte_t VAL_CHARGED      = 8'h00;
  localparam byte_t VAL_BLANK        = 8'hFF;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_PG_SETUP,
    PH_PG_DATA,
    PH_PG_PULSE,
    PH_PG_CHECK,
    PH_PG_READ,
    PH_ER_CMD_A,
    PH_ER_CMD_B,
    PH_ER_PULSE,
    PH_EV_CHECK,
    PH_EV_READ,
    PH_FINISH,
    PH_DONE,
    PH_FAIL
  } phase_t;
endpackage

// File: rtl/fe_bus_port.sv
module fe_bus_port
  import fe_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  byte_t             req_wdata,
  output logic              op_done,
  output byte_t             op_rdata,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output byte_t             bus_wdata,
  input  logic              rd_valid,
  input  byte_t             rd_data
);
  logic wait_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_valid <= 1'b0;
      bus_write <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      wait_rd   <= 1'b0;
      op_done   <= 1'b0;
      op_rdata  <= '0;
    end else begin
      op_done <= 1'b0;
      if (bus_valid) begin
        if (bus_ready) begin
          bus_valid <= 1'b0;
          if (bus_write) op_done <= 1'b1;
          else           wait_rd <= 1'b1;
        end
      end else if (wait_rd) begin
        if (rd_valid) begin
          wait_rd  <= 1'b0;
          op_rdata <= rd_data;
          op_done  <= 1'b1;
        end
      end else if (req && !op_done) begin
        bus_valid <= 1'b1;
        bus_write <= req_write;
        bus_addr  <= req_addr;
        bus_wdata <= req_wdata;
      end
    end
  end

  // R2: offered request is frozen until accepted
  a_r2_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_write));

  // R2: nothing offered while a read answer is pending
  a_r2_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    wait_rd |-> !bus_valid);
endmodule

// File: rtl/fe_pulse_timer.sv
module fe_pulse_timer #(
  parameter int TW = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [TW-1:0] len,
  output logic          expired
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (start)         cnt <= len;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == TW'(1));

  // R5: a pulse is never cut short by a new start
  a_r5_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    cnt != '0 |-> !start);
endmodule

// File: rtl/fe_sequencer.sv
module fe_sequencer
  import fe_pkg::*;
#(
  parameter int DEPTH           = 131072,
  parameter int ADDR_W          = 17,
  parameter int PROG_PULSE_CYC  = 2000,
  parameter int ERASE_PULSE_CYC = 2000000,
  parameter int PROG_TRIES      = 25,
  parameter int ERASE_MAX       = 1000,
  parameter int TW              = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_done,
  input  byte_t             op_rdata,
  output logic              req,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output byte_t             req_wdata,
  output logic              tmr_start,
  output logic [TW-1:0]     tmr_len,
  input  logic              tmr_expired,
  output logic              busy,
  output logic              done,
  output logic              fail
);
  localparam int TRY_W   = $clog2(PROG_TRIES + 1);
  localparam int PULSE_W = $clog2(ERASE_MAX + 1);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  phase_t               phase;
  logic [ADDR_W-1:0]    addr;
  logic [TRY_W-1:0]     tries;
  logic [PULSE_W-1:0]   pulses;

  function automatic logic erase_side(phase_t p);
    return p inside {PH_ER_CMD_A, PH_ER_CMD_B, PH_ER_PULSE, PH_EV_CHECK, PH_EV_READ};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      addr   <= '0;
      tries  <= '0;
      pulses <= '0;
    end else begin
      unique case (phase)
        PH_IDLE, PH_DONE, PH_FAIL: if (start) begin
          phase  <= PH_PG_SETUP;
          addr   <= '0;
          tries  <= '0;
          pulses <= '0;
        end
        PH_PG_SETUP: if (op_done) phase <= PH_PG_DATA;
        PH_PG_DATA:  if (op_done) phase <= PH_PG_PULSE;
        PH_PG_PULSE: if (tmr_expired) phase <= PH_PG_CHECK;
        PH_PG_CHECK: if (op_done) phase <= PH_PG_READ;
        PH_PG_READ: if (op_done) begin
          if (op_rdata == VAL_CHARGED) begin
            tries <= '0;
            if (addr == LAST_ADDR) begin
              addr  <= '0;
              phase <= PH_ER_CMD_A;
            end else begin
              addr  <= addr + 1'b1;
              phase <= PH_PG_SETUP;
            end
          end else if (tries + 1'b1 == TRY_W'(PROG_TRIES)) begin
            phase <= PH_FAIL;
          end else begin
            tries <= tries + 1'b1;
            phase <= PH_PG_SETUP;
          end
        end
        PH_ER_CMD_A: if (op_done) phase <= PH_ER_CMD_B;
        PH_ER_CMD_B: if (op_done) begin
          pulses <= pulses + 1'b1;
          phase  <= PH_ER_PULSE;
        end
        PH_ER_PULSE: if (tmr_expired) phase <= PH_EV_CHECK;
        PH_EV_CHECK: if (op_done) phase <= PH_EV_READ;
        PH_EV_READ: if (op_done) begin
          if (op_rdata == VAL_BLANK) begin
            if (addr == LAST_ADDR) phase <= PH_FINISH;
            else begin
              addr  <= addr + 1'b1;
              phase <= PH_EV_CHECK;
            end
          end else if (pulses == PULSE_W'(ERASE_MAX)) begin
            phase <= PH_FAIL;
          end else begin
            phase <= PH_ER_CMD_A;
          end
        end
        PH_FINISH: if (op_done) phase <= PH_DONE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    req       = 1'b1;
    req_write = 1'b1;
    req_addr  = addr;
    req_wdata = CMD_READ_ARRAY;
    unique case (phase)
      PH_PG_SETUP: req_wdata = CMD_PROG_SETUP;
      PH_PG_DATA:  req_wdata = VAL_CHARGED;
      PH_PG_CHECK: req_wdata = CMD_PROG_CHECK;
      PH_PG_READ:  req_write = 1'b0;
      PH_ER_CMD_A, PH_ER_CMD_B: begin
        req_wdata = CMD_ERASE;
        req_addr  = '0;
      end
      PH_EV_CHECK: req_wdata = CMD_ERASE_CHECK;
      PH_EV_READ:  req_write = 1'b0;
      PH_FINISH:   req_addr  = '0;
      default:     req       = 1'b0;
    endcase
  end

  assign tmr_start = op_done && (phase == PH_PG_DATA || phase == PH_ER_CMD_B);
  assign tmr_len   = (phase == PH_ER_CMD_B) ? TW'(ERASE_PULSE_CYC) : TW'(PROG_PULSE_CYC);

  assign busy = !(phase inside {PH_IDLE, PH_DONE, PH_FAIL});
  assign done = (phase == PH_DONE);
  assign fail = (phase == PH_FAIL);

  // R9: pulse count never passes the limit
  a_r9_pulse_cap: assert property (@(posedge clk) disable iff (!rst_n)
    pulses <= PULSE_W'(ERASE_MAX));

  // R7: within the erase loop the scan pointer never moves backward
  a_r7_scan_forward: assert property (@(posedge clk) disable iff (!rst_n)
    erase_side(phase) && erase_side($past(phase)) |-> addr >= $past(addr));

  // R8: done holds until a new start
  a_r8_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);

  // R11: outcomes exclusive
  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));

  // R10: start while busy does not re-enter the first phase
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    busy && phase != PH_PG_READ |=> !(phase == PH_PG_SETUP && addr == '0 && $past(phase) != PH_PG_SETUP));
endmodule

// File: rtl/flash_bulk_eraser.sv
module flash_bulk_eraser
  import fe_pkg::*;
#(
  parameter int DEPTH           = 131072,
  parameter int PROG_PULSE_CYC  = 2000,
  parameter int ERASE_PULSE_CYC = 2000000,
  parameter int PROG_TRIES      = 25,
  parameter int ERASE_MAX       = 1000,
  localparam int ADDR_W         = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [7:0]        bus_wdata,
  input  logic              rd_valid,
  input  logic [7:0]        rd_data,
  output logic              busy,
  output logic              done,
  output logic              fail
);
  localparam int TMAX = (ERASE_PULSE_CYC > PROG_PULSE_CYC) ? ERASE_PULSE_CYC : PROG_PULSE_CYC;
  localparam int TW   = $clog2(TMAX + 1);

  logic              req, req_write, op_done, tmr_start, tmr_expired;
  logic [ADDR_W-1:0] req_addr;
  byte_t             req_wdata, op_rdata;
  logic [TW-1:0]     tmr_len;

  fe_sequencer #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .PROG_PULSE_CYC(PROG_PULSE_CYC),
    .ERASE_PULSE_CYC(ERASE_PULSE_CYC), .PROG_TRIES(PROG_TRIES),
    .ERASE_MAX(ERASE_MAX), .TW(TW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .op_done(op_done), .op_rdata(op_rdata),
    .req(req), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .tmr_start(tmr_start), .tmr_len(tmr_len), .tmr_expired(tmr_expired),
    .busy(busy), .done(done), .fail(fail)
  );

  fe_pulse_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(tmr_start), .len(tmr_len), .expired(tmr_expired)
  );

  fe_bus_port #(.ADDR_W(ADDR_W)) u_port (
    .clk(clk), .rst_n(rst_n),
    .req(req), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .op_done(op_done), .op_rdata(op_rdata),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );
endmodule

// File: tb/flash_bulk_eraser_test.sv
module flash_bulk_eraser_test;
  localparam int DEPTH = 8;
  localparam int AW    = 3;
  localparam int PPC   = 5;
  localparam int EPC   = 20;
  localparam int PTRY  = 4;
  localparam int EMAX  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic bus_valid, bus_ready, bus_write, busy, done, fail;
  logic [AW-1:0] bus_addr;
  logic [7:0] bus_wdata;
  logic rd_valid = 1'b0;
  logic [7:0] rd_data = 8'h00;

  always #2.5 clk = ~clk;

  flash_bulk_eraser #(.DEPTH(DEPTH), .PROG_PULSE_CYC(PPC), .ERASE_PULSE_CYC(EPC),
                      .PROG_TRIES(PTRY), .ERASE_MAX(EMAX)) uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .busy(busy), .done(done), .fail(fail)
  );

  int checks = 0;
  int fails = 0;

  // array model state
  int  pneed[DEPTH];
  int  eneed[DEPTH];
  int  pcnt[DEPTH];
  logic [7:0] mem[DEPTH];
  int  cyc = 0;
  int  ready_mode = 0;
  bit  clr = 1'b0;
  int  epulses, a0_cnt, c0_cnt, erase_writes, min_pgap, min_egap, pstamp, estamp;
  int  stab_err, overlap_err, first_a0;
  bit  prog_next, e_half, zero_ok, saw_erase, pg_pend, eg_pend, read_cmd_seen, hold_pend, rd_out, rd_pend;
  logic [7:0] last_cmd, rd_val, h_wdata;
  logic [AW-1:0] h_addr;
  logic h_write;

  assign bus_ready = (ready_mode == 0) ? 1'b1 : (cyc % 3 == 0);

  function automatic bit all_charged();
    for (int i = 0; i < DEPTH; i++) if (mem[i] != 8'h00) return 1'b0;
    return 1'b1;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    rd_valid <= 1'b0;
    if (clr) begin
      for (int i = 0; i < DEPTH; i++) begin pcnt[i] <= 0; mem[i] <= 8'h5A; end
      epulses <= 0; a0_cnt <= 0; c0_cnt <= 0; erase_writes <= 0;
      min_pgap <= 1000000; min_egap <= 1000000; pg_pend <= 0; eg_pend <= 0;
      stab_err <= 0; overlap_err <= 0; first_a0 <= -1;
      prog_next <= 0; e_half <= 0; zero_ok <= 0; saw_erase <= 0; read_cmd_seen <= 0;
      hold_pend <= 0; rd_out <= 0; rd_pend <= 0; last_cmd <= 8'h00;
    end else begin
      if (hold_pend && !(bus_valid && bus_addr == h_addr && bus_wdata == h_wdata && bus_write == h_write))
        stab_err <= stab_err + 1;
      hold_pend <= bus_valid && !bus_ready;
      h_addr <= bus_addr; h_wdata <= bus_wdata; h_write <= bus_write;
      if (rd_out && bus_valid) overlap_err <= overlap_err + 1;
      if (rd_valid) rd_out <= 1'b0;
      if (rd_pend) begin rd_valid <= 1'b1; rd_data <= rd_val; rd_pend <= 1'b0; end
      if (bus_valid && bus_ready) begin
        if (pg_pend) begin
          if (cyc - pstamp < min_pgap) min_pgap <= cyc - pstamp;
          pg_pend <= 1'b0;
        end
        if (eg_pend) begin
          if (cyc - estamp < min_egap) min_egap <= cyc - estamp;
          eg_pend <= 1'b0;
        end
        if (bus_write) begin
          if (prog_next) begin
            prog_next <= 1'b0;
            pcnt[bus_addr] <= pcnt[bus_addr] + 1;
            if (pcnt[bus_addr] + 1 >= pneed[bus_addr]) mem[bus_addr] <= 8'h00;
            pstamp <= cyc; pg_pend <= 1'b1;
          end else begin
            last_cmd <= bus_wdata;
            if (bus_wdata != 8'h20) e_half <= 1'b0;
            case (bus_wdata)
              8'h40: prog_next <= 1'b1;
              8'h20: begin
                erase_writes <= erase_writes + 1;
                if (e_half) begin
                  e_half <= 1'b0;
                  epulses <= epulses + 1;
                  estamp <= cyc; eg_pend <= 1'b1;
                  if (!saw_erase) begin saw_erase <= 1'b1; zero_ok <= all_charged(); end
                end else e_half <= 1'b1;
              end
              8'hC0: c0_cnt <= c0_cnt + 1;
              8'hA0: begin
                a0_cnt <= a0_cnt + 1;
                if (first_a0 < 0) first_a0 <= int'(bus_addr);
              end
              8'h00: read_cmd_seen <= 1'b1;
              default: ;
            endcase
          end
        end else begin
          rd_pend <= 1'b1; rd_out <= 1'b1;
          rd_val <= (last_cmd == 8'hA0) ? ((epulses >= eneed[bus_addr]) ? 8'hFF : 8'h00) : mem[bus_addr];
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic prep();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic go();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_end();
    int n = 0;
    while (!(done || fail) && n < 20000) begin @(negedge clk); n++; end
    chk(n < 20000, "R8 run ends", n, 20000);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !fail && !bus_valid, "R1 reset state", {busy, done, fail, bus_valid}, 0);
  endtask

  task automatic t_basic();
    for (int i = 0; i < DEPTH; i++) pneed[i] = 1;
    eneed = '{1, 2, 1, 3, 3, 1, 2, 1};
    ready_mode = 0;
    prep(); go();
    chk(busy && !fail && !done, "R11 start clears outcome", {busy, done, fail}, 4);
    wait_end();
    chk(done && !fail && !busy, "R8 done raised", {done, fail, busy}, 4);
    chk(epulses == 3, "R7 pulse count with resume", epulses, 3);
    chk(a0_cnt == DEPTH + 2, "R7 A0 count", a0_cnt, DEPTH + 2);
    chk(first_a0 == 0, "R7 first scan at zero", first_a0, 0);
    chk(c0_cnt == DEPTH, "R3 one verify per byte", c0_cnt, DEPTH);
    chk(zero_ok, "R3 all bytes charged before erase", zero_ok, 1);
    chk(min_pgap >= PPC, "R3 program pulse length", min_pgap, PPC);
    chk(min_egap >= EPC, "R5 erase pulse length", min_egap, EPC);
    chk(erase_writes == 6, "R5 two 20H per pulse", erase_writes, 6);
    chk(read_cmd_seen, "R8 read command written", read_cmd_seen, 1);
    chk(stab_err == 0 && overlap_err == 0, "R2 bus rules", stab_err + overlap_err, 0);
    repeat (5) @(negedge clk);
    chk(done, "R8 done held", done, 1);
  endtask

  task automatic t_backpressure();
    pneed = '{1, 2, 1, 3, 1, 1, 2, 1};
    eneed = '{2, 1, 1, 1, 4, 1, 1, 2};
    ready_mode = 1;
    prep(); go();
    repeat (30) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_end();
    chk(done && !fail, "R10 stray start ignored, run completes", done, 1);
    chk(epulses == 4, "R10 pulse count unchanged", epulses, 4);
    chk(a0_cnt == DEPTH + 3, "R6 A0 count under backpressure", a0_cnt, DEPTH + 3);
    chk(c0_cnt == 12, "R3 retries counted", c0_cnt, 12);
    for (int i = 0; i < DEPTH; i++)
      chk(pcnt[i] == pneed[i], "R3 program pulses per byte", pcnt[i], pneed[i]);
    chk(stab_err == 0, "R2 request held while not ready", stab_err, 0);
    chk(overlap_err == 0, "R2 no request before read returns", overlap_err, 0);
    ready_mode = 0;
  endtask

  task automatic t_prog_fail();
    for (int i = 0; i < DEPTH; i++) begin pneed[i] = 1; eneed[i] = 1; end
    pneed[3] = PTRY + 1;
    prep(); go();
    wait_end();
    chk(fail && !done, "R4 fail on program limit", fail, 1);
    chk(pcnt[3] == PTRY, "R4 exact tries", pcnt[3], PTRY);
    chk(erase_writes == 0, "R4 no erase after program fail", erase_writes, 0);
  endtask

  task automatic t_erase_fail();
    for (int i = 0; i < DEPTH; i++) begin pneed[i] = 1; eneed[i] = 1; end
    eneed[5] = EMAX + 1;
    prep(); go();
    wait_end();
    chk(fail && !done, "R9 fail on erase limit", fail, 1);
    chk(epulses == EMAX, "R9 pulses stop at limit", epulses, EMAX);
    chk(erase_writes == 2 * EMAX, "R9 no extra erase writes", erase_writes, 2 * EMAX);
    repeat (10) @(negedge clk);
    chk(erase_writes == 2 * EMAX && fail, "R9 quiet after fail", erase_writes, 2 * EMAX);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin pneed[i] = 1; eneed[i] = 1; end
    clr = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    clr = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_backpressure();
    t_prog_fail();
    t_erase_fail();
    t_basic();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule